// File: doc/BRIEF.md
# Chained Byte Multiply-Accumulate Unit

This unit is the multiplier of a small accumulator-based processor. It multiplies an 8-bit operand by an 8-bit factor and returns a 16-bit result. The upper byte stays in a high-product register inside the unit, and the lower byte is returned as the new accumulator value. A factor register holds a multiplier byte between instructions. The plain multiply fills that register from the accumulator. A separate opcode loads it straight from the operand.

The multiply-add operation starts its sum from the retained high-product byte. It then adds operand times the stored factor. A long number can therefore be multiplied by one byte by issuing multiply-add once per byte, least significant byte first. Each step returns one result byte, and the final high-product byte is the top byte. The sum never exceeds 255 + 255*255 = 65280, so it always fits in 16 bits and no carry leaves the unit.

An instruction lasts four clocks. A shift-and-add datapath retires two factor bits per clock. Both destination registers are written together with a one-clock done pulse.

Top module: `mac_chain_unit`

## Requirements
- R1: Opcode 2'b00 (plain multiply) with an accepted strobe yields prod_hi = bits 15:8 and acc_out = bits 7:0 of operand * acc_in.
- R2: The plain multiply copies acc_in into the factor register, which is visible on mult_reg.
- R3: Opcode 2'b01 (multiply-add) yields {prod_hi, acc_out} = previous prod_hi + operand * mult_reg, taken modulo 2^16. The result always fits in 16 bits, for example 0xFE + 0xFF*0xFF = 0xFEFF.
- R4: A strobe is accepted on a rising edge where op_valid is 1 and busy is 0. For a multiply, busy is 1 for the next 4 clocks. On the 4th of those clocks, prod_hi and acc_out are updated together and done pulses for exactly one clock. prod_hi and acc_out change at no other time.
- R5: Opcode 2'b10 loads mult_reg from operand, visible one clock after the accepting edge. It produces no done pulse and leaves prod_hi and acc_out unchanged.
- R6: A strobe that arrives while busy is 1 is ignored. It changes neither the running result nor mult_reg.
- R7: Reset clears prod_hi, acc_out, mult_reg, busy and done to 0.
- R8: Opcode 2'b11 has no effect: no busy, no done, and no register change.
- R9: Chaining is supported. A plain multiply of the lowest byte is followed by multiply-adds of the higher bytes, with the same factor. The collected acc_out bytes followed by the final prod_hi form the full product of a 4-byte value and one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 2 | Operation select (00 multiply, 01 multiply-add, 10 load factor, 11 none) |
| operand | input | 8 | Operand byte |
| acc_in | input | 8 | Current accumulator value |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-clock pulse when results are written |
| acc_out | output | 8 | Low result byte, for the accumulator |
| prod_hi | output | 8 | High-product register |
| mult_reg | output | 8 | Stored factor register |

## Verification
A multiply result is due on the fifth rising edge after the clock in which the strobe is driven: one edge accepts the strobe and four edges perform the shift-and-add steps. The scoreboard stores the cycle number at issue with each expected item. The monitor, sampling on falling edges, rejects any done pulse that does not arrive exactly five edges later. A factor load is due one edge after acceptance, so it is checked at the next falling edge. Strobes that must be ignored are driven in the falling edges between acceptance and done. Their absence of effect is then read on mult_reg and on the scoreboard result.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [1:0] {
        OP_MUL    = 2'b00,
        OP_MULADD = 2'b01,
        OP_LDFAC  = 2'b10,
        OP_NONE   = 2'b11
    } mac_op_e;
endpackage

// File: rtl/mac_seq.sv
// Step sequencer: counts the shift-and-add clocks and emits done.
module mac_seq #(
    parameter int unsigned STEPS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic last,
    output logic done
);
    localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (s_q.busy) begin
            if (s_q.cnt == CW'(STEPS - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign done = s_q.done;
    assign last = s_q.busy && (s_q.cnt == CW'(STEPS - 1));
endmodule

// File: rtl/mac_shift_add.sv
// Shift-and-add datapath retiring BPC factor bits per step.
module mac_shift_add #(
    parameter int unsigned DW  = 8,
    parameter int unsigned BPC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [DW-1:0]   mcand_in,
    input  logic [DW-1:0]   mplr_in,
    input  logic [DW-1:0]   addend_in,
    output logic [2*DW-1:0] step_sum
);
    localparam int unsigned PW = 2 * DW;

    typedef struct packed {
        logic [PW-1:0] mcand;
        logic [DW-1:0] mplr;
        logic [PW-1:0] acc;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [PW-1:0] terms [BPC];

    for (genvar j = 0; j < BPC; j++) begin : g_term
        assign terms[j] = dp_q.mplr[j] ? (dp_q.mcand << j) : '0;
    end

    always_comb begin
        step_sum = dp_q.acc;
        for (int j = 0; j < BPC; j++) begin
            step_sum = step_sum + terms[j];
        end
    end

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.mcand = {{DW{1'b0}}, mcand_in};
            dp_d.mplr  = mplr_in;
            dp_d.acc   = {{DW{1'b0}}, addend_in};
        end else if (step) begin
            dp_d.mcand = dp_q.mcand << BPC;
            dp_d.mplr  = dp_q.mplr >> BPC;
            dp_d.acc   = step_sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end
endmodule

// File: rtl/mac_result_regs.sv
// High-product, low-result and factor registers.
module mac_result_regs #(
    parameter int unsigned DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fac_load,
    input  logic [DW-1:0]   fac_val,
    input  logic            res_wr,
    input  logic [2*DW-1:0] res_val,
    output logic [DW-1:0]   prod_hi,
    output logic [DW-1:0]   acc_out,
    output logic [DW-1:0]   mult_reg
);
    typedef struct packed {
        logic [DW-1:0] hi;
        logic [DW-1:0] lo;
        logic [DW-1:0] fac;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (fac_load) r_d.fac = fac_val;
        if (res_wr) begin
            r_d.hi = res_val[2*DW-1:DW];
            r_d.lo = res_val[DW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign prod_hi  = r_q.hi;
    assign acc_out  = r_q.lo;
    assign mult_reg = r_q.fac;
endmodule

// File: rtl/mac_chain_unit.sv
module mac_chain_unit #(
    parameter int unsigned DW  = 8,
    parameter int unsigned BPC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [1:0]    op_code,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] acc_in,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] acc_out,
    output logic [DW-1:0] prod_hi,
    output logic [DW-1:0] mult_reg
);
    import mac_pkg::*;

    localparam int unsigned STEPS = DW / BPC;

    logic            accept, is_mul, is_mula, is_ldf, start, last;
    logic            fac_load;
    logic [DW-1:0]   fac_val, mplr_sel, addend_sel;
    logic [2*DW-1:0] step_sum;

    assign accept     = op_valid && !busy;
    assign is_mul     = (mac_op_e'(op_code) == OP_MUL);
    assign is_mula    = (mac_op_e'(op_code) == OP_MULADD);
    assign is_ldf     = (mac_op_e'(op_code) == OP_LDFAC);
    assign start      = accept && (is_mul || is_mula);
    assign fac_load   = accept && (is_mul || is_ldf);
    assign fac_val    = is_mul ? acc_in : operand;
    assign mplr_sel   = is_mul ? acc_in : mult_reg;
    assign addend_sel = is_mula ? prod_hi : '0;

    mac_seq #(.STEPS(STEPS)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .last  (last),
        .done  (done)
    );

    mac_shift_add #(.DW(DW), .BPC(BPC)) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .step      (busy),
        .mcand_in  (operand),
        .mplr_in   (mplr_sel),
        .addend_in (addend_sel),
        .step_sum  (step_sum)
    );

    mac_result_regs #(.DW(DW)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fac_load (fac_load),
        .fac_val  (fac_val),
        .res_wr   (last),
        .res_val  (step_sum),
        .prod_hi  (prod_hi),
        .acc_out  (acc_out),
        .mult_reg (mult_reg)
    );
endmodule

// File: rtl/mac_chain_chk.sv
module mac_chain_chk #(
    parameter int unsigned DW  = 8,
    parameter int unsigned BPC = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] acc_out,
    input logic [DW-1:0] prod_hi,
    input logic [DW-1:0] mult_reg
);
    localparam int unsigned STEPS = DW / BPC;
    localparam int unsigned KW    = $clog2(STEPS + 1) + 1;

    logic [KW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_cnt == KW'(STEPS))); // R4
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt < KW'(STEPS))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R4
    AST_HI_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(prod_hi)); // R4
    AST_LO_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(acc_out)); // R4
    AST_FAC_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(mult_reg)); // R6
endmodule

bind mac_chain_unit mac_chain_chk #(.DW(DW), .BPC(BPC)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .acc_out  (acc_out),
    .prod_hi  (prod_hi),
    .mult_reg (mult_reg)
);

// File: tb/mac_chain_unit_tb.sv
module mac_chain_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_code = 2'b11;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic       busy, done;
    logic [7:0] acc_out, prod_hi, mult_reg;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] fac;
        int         cyc;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] m_hi = 8'h00, m_fac = 8'h00, last_lo = 8'h00;

    mac_chain_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .acc_in(acc_in), .busy(busy), .done(done),
        .acc_out(acc_out), .prod_hi(prod_hi), .mult_reg(mult_reg)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Driver: one strobe, expected result pushed for multiplies.
    task automatic issue(input logic [1:0] code, input logic [7:0] opnd, input logic [7:0] acc);
        logic [15:0] p;
        exp_t e;
        @(negedge clk);
        op_valid = 1'b1; op_code = code; operand = opnd; acc_in = acc;
        if (code == 2'b00) begin
            p = 16'(opnd) * 16'(acc);
            m_fac = acc;
        end else if (code == 2'b01) begin
            p = 16'(m_hi) + 16'(opnd) * 16'(m_fac);
        end else begin
            p = 16'h0;
            if (code == 2'b10) m_fac = opnd;
        end
        if (code[1] == 1'b0) begin
            m_hi  = p[15:8];
            e.hi  = p[15:8]; e.lo = p[7:0]; e.fac = m_fac; e.cyc = cyc;
            exp_q.push_back(e);
        end
        @(negedge clk);
        op_valid = 1'b0;
        if (code[1] == 1'b0) chk("R4 busy after accept", 32'(busy), 32'd1);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops and compares at each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R4 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R1/R3 prod_hi", 32'(prod_hi), 32'(e.hi));
                chk("R1/R3 acc_out", 32'(acc_out), 32'(e.lo));
                chk("R2 mult_reg", 32'(mult_reg), 32'(e.fac));
                chk("R4 latency", 32'(cyc), 32'(e.cyc + 5));
                last_lo = acc_out;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            report();
        end
    end

    initial begin
        logic [7:0]  held;
        logic [31:0] xv;
        logic [39:0] prod, got;
        repeat (3) @(negedge clk);
        chk("R7 prod_hi reset", 32'(prod_hi), 32'h0);
        chk("R7 acc_out reset", 32'(acc_out), 32'h0);
        chk("R7 mult_reg reset", 32'(mult_reg), 32'h0);
        chk("R7 busy reset", 32'(busy), 32'h0);
        chk("R7 done reset", 32'(done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2 plain multiply, corners
        issue(2'b00, 8'h12, 8'h34); wait_idle();
        issue(2'b00, 8'hFF, 8'hFF); wait_idle();
        issue(2'b00, 8'h00, 8'hA5); wait_idle();
        // R3 multiply-add from hi=0xFE with factor 0xFF, maximum
        issue(2'b00, 8'hFF, 8'hFF); wait_idle();
        issue(2'b01, 8'hFF, 8'h00); wait_idle();
        chk("R3 max sum hi", 32'(prod_hi), 32'hFE);
        chk("R3 max sum lo", 32'(acc_out), 32'hFF);

        // R5 load factor directly
        held = prod_hi;
        issue(2'b10, 8'h3C, 8'h00);
        chk("R5 mult_reg loaded", 32'(mult_reg), 32'h3C);
        chk("R5 no done", 32'(done), 32'h0);
        chk("R5 prod_hi kept", 32'(prod_hi), 32'(held));
        issue(2'b01, 8'h07, 8'h00); wait_idle();

        // R8 no-operation opcode
        held = prod_hi;
        issue(2'b11, 8'h99, 8'h77);
        chk("R8 busy", 32'(busy), 32'h0);
        @(negedge clk);
        chk("R8 mult_reg", 32'(mult_reg), 32'(m_fac));
        chk("R8 prod_hi", 32'(prod_hi), 32'(held));
        chk("R8 done", 32'(done), 32'h0);

        // R6 strobes while busy ignored
        issue(2'b00, 8'h21, 8'h43);
        op_valid = 1'b1; op_code = 2'b10; operand = 8'h5A;
        @(negedge clk);
        op_code = 2'b01; operand = 8'hEE;
        @(negedge clk);
        op_valid = 1'b0;
        wait_idle();
        chk("R6 mult_reg after ignored", 32'(mult_reg), 32'h43);
        chk("R6 queue drained", 32'(exp_q.size()), 32'h0);

        // Random mix of multiply and multiply-add
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a, b;
            a = 8'($urandom); b = 8'($urandom);
            issue({1'b0, 1'($urandom)}, a, b); wait_idle();
        end

        // R9 chained 4-byte by 1-byte product
        for (int t = 0; t < 3; t++) begin
            logic [7:0] f;
            xv = $urandom; f = 8'($urandom);
            if (t == 0) begin xv = 32'hFFFF_FFFF; f = 8'hFF; end
            prod = 40'(xv) * 40'(f);
            issue(2'b00, xv[7:0], f); wait_idle(); got[7:0] = last_lo;
            issue(2'b01, xv[15:8], 8'h00); wait_idle(); got[15:8] = last_lo;
            issue(2'b01, xv[23:16], 8'h00); wait_idle(); got[23:16] = last_lo;
            issue(2'b01, xv[31:24], 8'h00); wait_idle(); got[31:24] = last_lo;
            got[39:32] = prod_hi;
            chk("R9 chain low word", got[31:0], prod[31:0]);
            chk("R9 chain top byte", 32'(got[39:32]), 32'(prod[39:32]));
        end

        chk("R4 all results seen", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        report();
    end
endmodule